// File: doc/BRIEF.md
# Event Prescaler with Edge-Count Snapshot

This block slows down a single event line so it can serve as a measurement trigger. The incoming event is brought into the system clock domain and its rising edges are detected. A divider then flips its output after a fixed number of those edges. One select input sets a fast ratio, where the output flips every 8th edge for one output rising edge per 16 input edges. The other setting is a slow ratio, where it flips every 32nd edge for one output rising edge per 64 input edges.

Alongside the divider, a free-running 16-bit counter tallies every detected input edge. Software does not read this counter directly. A write strobe copies it into a snapshot register, and the snapshot stays put until the next strobe. A run-enable input acts as an active-low software reset for the divider and the counter. The event source feeding the block should only be switched while run-enable is low.

Top module: `evt_prescaler`

## Requirements
- R1: After `rst_n` is released, `evt_out` is 0 and `snap_cnt` is 0.
- R2: While `run_en` is 0, `evt_out` is held at 0, the divider phase and the edge counter are held at 0, and input edges are not counted. A snapshot taken after such edges reads 0.
- R3: With `run_en` 1 and `ratio_sel` 0, `evt_out` flips on every 8th detected input rising edge and does not change on any other cycle.
- R4: With `run_en` 1 and `ratio_sel` 1, `evt_out` flips on every 32nd detected input rising edge.
- R5: In the cycle after `latch_wr` is sampled high, `snap_cnt` equals the edge counter's value. With no strobe, `snap_cnt` keeps its value.
- R6: The 16-bit edge counter wraps from 0xFFFF to 0 on the next edge.
- R7: When a strobe and an input edge are sampled on the same clock edge, the snapshot holds the count from before that edge.
- R8: `evt_in` passes through a two-flop synchronizer. A 0-to-1 change in `evt_in` is counted once, on the third clock edge after it is first sampled high, however long the input then stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 runs the prescaler; 0 holds divider and counter cleared |
| ratio_sel | input | 1 | 0: flip every 8 edges; 1: flip every 32 edges |
| evt_in | input | 1 | Asynchronous event input |
| latch_wr | input | 1 | One-cycle strobe that copies the edge counter into `snap_cnt` |
| evt_out | output | 1 | Divided event output |
| snap_cnt | output | 16 | Last captured edge count |

## Verification
A snapshot strobe and a counted input edge can land on the same clock edge. The counter then changes in the same cycle that it is being copied. The bench sets this up by raising `latch_wr` exactly two cycles after `evt_in` first rises, which is the cycle the synchronized edge is consumed. It judges the result by requiring the pre-increment count in `snap_cnt`, and it takes a second snapshot to confirm that the increment itself was not lost. A strobe that arrives while `run_en` drops falls under the same rule: the value held before the clear is captured.

// File: rtl/evt_prescaler_pkg.sv
package evt_prescaler_pkg;

   typedef enum logic {
      RATIO_FAST = 1'b0,
      RATIO_SLOW = 1'b1
   } ratio_e;

   function automatic int unsigned phase_width(input int unsigned half_max);
      return (half_max <= 2) ? 1 : $clog2(half_max);
   endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   // chain[0..STAGES-1] synchronize, chain[STAGES] remembers the previous level
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= async_in;
   end

   for (genvar g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g] <= 1'b0;
         else        chain[g] <= chain[g-1];
      end
   end

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/evt_toggle_div.sv
module evt_toggle_div #(
   parameter int unsigned FAST_HALF = 8,
   parameter int unsigned SLOW_HALF = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ratio,
   input  logic step,
   output logic out
);
   import evt_prescaler_pkg::*;

   localparam int unsigned HMAX = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
   localparam int unsigned DW   = phase_width(HMAX);
   localparam logic [DW-1:0] FAST_LAST = DW'(FAST_HALF - 1);
   localparam logic [DW-1:0] SLOW_LAST = DW'(SLOW_HALF - 1);

   logic [DW-1:0] phase;
   logic [DW-1:0] last;

   always_comb begin
      last = (ratio_e'(ratio) == RATIO_SLOW) ? SLOW_LAST : FAST_LAST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         out   <= 1'b0;
      end else if (!run) begin
         phase <= '0;
         out   <= 1'b0;
      end else if (step) begin
         if (phase >= last) begin
            phase <= '0;
            out   <= ~out;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end
endmodule

// File: rtl/evt_edge_counter.sv
module evt_edge_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic             latch,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] snap_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_o <= '0;
      else if (!run)  count_o <= '0;
      else if (step)  count_o <= count_o + 1'b1;
   end

   // captures the register value, i.e. before any same-cycle increment
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     snap_o <= '0;
      else if (latch) snap_o <= count_o;
   end
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned FAST_HALF   = 8,
   parameter int unsigned SLOW_HALF   = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             ratio_sel,
   input  logic             evt_in,
   input  logic             latch_wr,
   output logic             evt_out,
   output logic [CNT_W-1:0] snap_cnt
);
   if (CNT_W < 2)       begin : g_bad_cnt   $error("CNT_W must be at least 2");        end
   if (FAST_HALF < 1)   begin : g_bad_fast  $error("FAST_HALF must be at least 1");    end
   if (SLOW_HALF < 1)   begin : g_bad_slow  $error("SLOW_HALF must be at least 1");    end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2");  end

   logic             rise_w;
   logic [CNT_W-1:0] count_w;

   evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (evt_in),
      .rise_o   (rise_w)
   );

   evt_toggle_div #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_en),
      .ratio (ratio_sel),
      .step  (rise_w),
      .out   (evt_out)
   );

   evt_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_en),
      .step    (rise_w),
      .latch   (latch_wr),
      .count_o (count_w),
      .snap_o  (snap_cnt)
   );
endmodule

// File: rtl/evt_prescaler_chk.sv
module evt_prescaler_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             latch_wr,
   input logic             rise,
   input logic [CNT_W-1:0] count,
   input logic             evt_out,
   input logic [CNT_W-1:0] snap_cnt
);
   // R2
   held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !evt_out);

   // R2
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (count == '0));

   // R3
   out_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !rise) |=> $stable(evt_out));

   // R5
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_wr |=> $stable(snap_cnt));

   // R7
   snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_wr |=> (snap_cnt == $past(count)));

   // R6
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && rise && (count == {CNT_W{1'b1}})) |=> (count == '0));
endmodule

bind evt_prescaler evt_prescaler_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .latch_wr (latch_wr),
   .rise     (rise_w),
   .count    (count_w),
   .evt_out  (evt_out),
   .snap_cnt (snap_cnt)
);

// File: tb/tb_evt_prescaler.sv
`timescale 1ns/1ps
module tb_evt_prescaler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        ratio_sel = 1'b0;
   logic        evt_in = 1'b0;
   logic        latch_wr = 1'b0;
   logic        evt_out;
   logic [15:0] snap_cnt;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit cmp_on = 1'b0;

   // behavioural reference state
   bit      h0, h1, h2, medge, mout;
   int      mcnt, mdiv, msnap;

   always #10 clk = ~clk;

   evt_prescaler dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .ratio_sel(ratio_sel),
      .evt_in(evt_in), .latch_wr(latch_wr), .evt_out(evt_out), .snap_cnt(snap_cnt)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         h0 = 0; h1 = 0; h2 = 0; mcnt = 0; mdiv = 0; mout = 0; msnap = 0;
      end else begin
         medge = h1 && !h2;
         h2 = h1; h1 = h0; h0 = evt_in;
         if (latch_wr) msnap = mcnt;
         if (!run_en) begin
            mcnt = 0; mdiv = 0; mout = 0;
         end else if (medge) begin
            mcnt = (mcnt + 1) % 65536;
            mdiv = mdiv + 1;
            if (mdiv >= (ratio_sel ? 32 : 8)) begin
               mout = !mout; mdiv = 0;
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R3 R4 for the output, R5 for the snapshot)
   always @(negedge clk) begin
      cycles++;
      if (cmp_on) begin
         check("R3 R4 evt_out vs model", int'(evt_out), int'(mout));
         check("R5 snap_cnt vs model", int'(snap_cnt), msnap);
      end
      if (cycles > 190000) begin
         fails++;
         $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) evt_in = 1'b1;
         @(negedge clk) evt_in = 1'b0;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic snap();
      @(negedge clk) latch_wr = 1'b1;
      @(negedge clk) latch_wr = 1'b0;
   endtask

   task automatic restart();
      @(negedge clk) run_en = 1'b0;
      @(negedge clk) run_en = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk);
      check("R1 evt_out after reset", int'(evt_out), 0);
      check("R1 snap_cnt after reset", int'(snap_cnt), 0);

      // R2: edges while held in reset are not counted
      edges(10);
      check("R2 evt_out held low", int'(evt_out), 0);
      snap();
      check("R2 no count while held", int'(snap_cnt), 0);

      // R3: fast ratio
      run_en = 1'b1;
      edges(7);
      check("R3 no flip before 8th edge", int'(evt_out), 0);
      edges(1);
      check("R3 flip on 8th edge", int'(evt_out), 1);
      edges(8);
      check("R3 flip back on 16th edge", int'(evt_out), 0);
      snap();
      check("R5 snapshot of 16 edges", int'(snap_cnt), 16);
      edges(3);
      check("R5 snapshot holds without strobe", int'(snap_cnt), 16);

      // R4: slow ratio
      ratio_sel = 1'b1;
      restart();
      edges(31);
      check("R4 no flip before 32nd edge", int'(evt_out), 0);
      edges(1);
      check("R4 flip on 32nd edge", int'(evt_out), 1);
      restart();
      check("R2 run_en low clears output", int'(evt_out), 0);

      // R8: long high level counts once
      restart();
      @(negedge clk) evt_in = 1'b1;
      repeat (20) @(negedge clk);
      evt_in = 1'b0;
      repeat (3) @(negedge clk);
      snap();
      check("R8 held-high input counts once", int'(snap_cnt), 1);

      // R7: strobe on the same clock edge as an edge is consumed
      restart();
      edges(5);
      @(negedge clk) evt_in = 1'b1;
      @(negedge clk);
      @(negedge clk) latch_wr = 1'b1;
      @(negedge clk) latch_wr = 1'b0; evt_in = 1'b0;
      check("R7 coincident snapshot is pre-increment", int'(snap_cnt), 5);
      repeat (2) @(negedge clk);
      snap();
      check("R7 coincident edge still counted", int'(snap_cnt), 6);

      // R6: wrap of the 16-bit counter
      ratio_sel = 1'b0;
      restart();
      for (int i = 0; i < 65535; i++) begin
         @(negedge clk) evt_in = 1'b1;
         @(negedge clk) evt_in = 1'b0;
      end
      repeat (3) @(negedge clk);
      snap();
      check("R6 count at all ones", int'(snap_cnt), 65535);
      edges(1);
      snap();
      check("R6 wrap to zero", int'(snap_cnt), 0);
      edges(1);
      snap();
      check("R6 counts on after wrap", int'(snap_cnt), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule